// File: doc/BRIEF.md
# Dequantizing 8-Point Inverse DCT Column Stage

This block does the first of two one-dimensional passes of an integer 8x8 inverse DCT. Each accepted column holds eight signed 16-bit transform coefficients. Every coefficient is first scaled by its own 16-bit quantizer step. The block then applies an even/odd butterfly whose multipliers are fixed integers with 13 fractional bits. Each of the eight results is rounded and cut back to signed 16 bits. Two fractional bits are kept in these results for the pass that follows.

The quantizer column is held in a register inside the block. A separate strobe loads it, and the stored copy is used for every later column. A column and a new quantizer set may arrive in the same cycle. The pipeline is three register stages deep: dequantize, rotate, descale. It accepts one column in every clock cycle and never stalls. Lane `i` of every 128-bit bus sits at bits `[16*i +: 16]`, and lane 0 is the DC term.

Top module: `idct_col_core`

## Requirements
- R1: Lane `i` of the dequantized input is the low 16 bits of the signed product of coefficient lane `i` and quantizer lane `i`. Products that overflow wrap and do not saturate.
- R2: When `quant_valid` is high, the quantizer register takes `quant_col`. The stored column is used for every later column until the next load.
- R3: If `quant_valid` and `coef_valid` are high in the same cycle, that column is dequantized with the new `quant_col`, not with the old stored value.
- R4: While `rst_n` is low, `out_valid` is 0 and `out_col` is all zero. After reset, the stored quantizer is all zero, so a column sent before any load gives all-zero outputs.
- R5: Take a column whose only non-zero dequantized term is the DC term `d`, and suppose `4*d` fits in 16 bits. All eight outputs then equal `4*d`.
- R6: Output lane `k` is the inverse DCT of the dequantized column. The even half uses terms 0, 2, 4, 6 and the odd half uses terms 1, 3, 5, 7. Lanes 0–3 take the even term plus the odd term. Lanes 4–7 take the mirrored difference: lane `7-k` pairs the same two terms as lane `k`. All of this uses 32-bit signed wrapping arithmetic.
- R7: Each 32-bit sum is rounded by adding 1024 and then shifting right arithmetically by 11 bits.
- R8: The rounded value is narrowed to its low 16 bits with no saturation. A DC-only column with dequantized DC 32767 gives -4 on every lane.
- R9: `out_valid` goes high exactly 3 clock edges after an edge that samples `coef_valid` high. A new column may be accepted on every edge.
- R10: While `out_valid` is low, `out_col` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| coef_valid | input | 1 | A coefficient column is present on `coef_col` |
| coef_col | input | 128 | Eight signed 16-bit coefficients; lane 0 is DC |
| quant_valid | input | 1 | Load `quant_col` into the quantizer register |
| quant_col | input | 128 | Eight signed 16-bit quantizer steps |
| out_valid | output | 1 | `out_col` holds a new result |
| out_col | output | 128 | Eight signed 16-bit intermediate values, two fractional bits |

## Verification
Two events can happen in the same edge: a quantizer load and the capture of a column. The bench provokes this by driving a column together with a quantizer set that differs from the stored one. It then sends a following column with `quant_valid` low. The expected output of the first column must match the new set, and the second column must still use that set, which shows the load was both bypassed and retained. Back-to-back columns with random gaps run against a behavioural model written in the unmerged rotation form. Every cycle, that model checks both the output data and the exact cycle of `out_valid`.

// File: rtl/idct_col_pkg.sv
package idct_col_pkg;

  // Lane geometry
  localparam int COEF_W     = 16;
  localparam int ACC_W      = 32;
  localparam int LANES      = 8;
  localparam int HALF       = LANES / 2;
  localparam int COL_W      = COEF_W * LANES;
  localparam int HALF_W     = ACC_W * HALF;

  // Fixed-point scaling
  localparam int FRAC_BITS  = 13;
  localparam int KEEP_BITS  = 2;
  localparam int DESCALE    = FRAC_BITS - KEEP_BITS;
  localparam int RND_HALF   = 1 << (DESCALE - 1);

  // Pipeline depth, input edge to output register
  localparam int LATENCY    = 3;

  // Rotation multipliers, value * 2^13
  localparam int M_0298 = 2446;
  localparam int M_0390 = 3196;
  localparam int M_0541 = 4433;
  localparam int M_0765 = 6270;
  localparam int M_0899 = 7373;
  localparam int M_1175 = 9633;
  localparam int M_1501 = 12299;
  localparam int M_1847 = 15137;
  localparam int M_1961 = 16069;
  localparam int M_2053 = 16819;
  localparam int M_2562 = 20995;
  localparam int M_3072 = 25172;

  // Merged coefficients so each rotation term is two products
  localparam int E_LO   = M_0541 - M_1847;
  localparam int E_HI   = M_0541 + M_0765;
  localparam int O_Z3A  = M_1175 - M_1961;
  localparam int O_Z4B  = M_1175 - M_0390;
  localparam int O_T0   = M_0298 - M_0899;
  localparam int O_T1   = M_2053 - M_2562;
  localparam int O_T2   = M_3072 - M_2562;
  localparam int O_T3   = M_1501 - M_0899;

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  function automatic acc_t widen(input coef_t x);
    return acc_t'(x);
  endfunction

  function automatic acc_t kmul(input acc_t x, input int k);
    return x * acc_t'(k);
  endfunction

endpackage

// File: rtl/idct_dequant.sv
module idct_dequant
  import idct_col_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coef_valid,
  input  logic [COL_W-1:0] coef_col,
  input  logic             quant_valid,
  input  logic [COL_W-1:0] quant_col,
  output logic             dq_valid,
  output logic [COL_W-1:0] dq_col
);

  logic [COL_W-1:0] qtab_q, qtab_nxt;
  logic [COL_W-1:0] q_eff;
  logic [COL_W-1:0] prod_all;
  logic [COL_W-1:0] dq_q, dq_nxt;
  logic             vld_q, vld_nxt;

  // A load in the same cycle as a column is forwarded to that column
  assign q_eff = quant_valid ? quant_col : qtab_q;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      coef_t c_l, q_l, p_l;
      assign c_l = coef_t'(coef_col[gi*COEF_W +: COEF_W]);
      assign q_l = coef_t'(q_eff[gi*COEF_W +: COEF_W]);
      assign p_l = coef_t'(c_l * q_l);
      assign prod_all[gi*COEF_W +: COEF_W] = p_l;
    end
  endgenerate

  always_comb begin
    qtab_nxt = qtab_q;
    dq_nxt   = dq_q;
    vld_nxt  = coef_valid;
    if (quant_valid) qtab_nxt = quant_col;
    if (coef_valid)  dq_nxt   = prod_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qtab_q <= '0;
      dq_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      qtab_q <= qtab_nxt;
      dq_q   <= dq_nxt;
      vld_q  <= vld_nxt;
    end
  end

  assign dq_valid = vld_q;
  assign dq_col   = dq_q;

endmodule

// File: rtl/idct_even.sv
module idct_even
  import idct_col_pkg::*;
(
  input  coef_t             x0,
  input  coef_t             x2,
  input  coef_t             x4,
  input  coef_t             x6,
  output logic [HALF_W-1:0] ev_vec
);

  acc_t p_lo, p_hi, s_sum, s_dif;
  acc_t e10, e11, e12, e13;

  always_comb begin
    p_lo  = kmul(widen(x2), M_0541) + kmul(widen(x6), E_LO);
    p_hi  = kmul(widen(x2), E_HI)   + kmul(widen(x6), M_0541);
    s_sum = (widen(x0) + widen(x4)) <<< FRAC_BITS;
    s_dif = (widen(x0) - widen(x4)) <<< FRAC_BITS;
    e10   = s_sum + p_hi;
    e13   = s_sum - p_hi;
    e11   = s_dif + p_lo;
    e12   = s_dif - p_lo;
  end

  // Slot k carries the even term paired with output lane k
  assign ev_vec = {e13, e12, e11, e10};

endmodule

// File: rtl/idct_odd.sv
module idct_odd
  import idct_col_pkg::*;
(
  input  coef_t             x1,
  input  coef_t             x3,
  input  coef_t             x5,
  input  coef_t             x7,
  output logic [HALF_W-1:0] od_vec
);

  acc_t s73, s51, r3, r4;
  acc_t o0, o1, o2, o3;

  always_comb begin
    s73 = widen(x7) + widen(x3);
    s51 = widen(x5) + widen(x1);
    r3  = kmul(s73, O_Z3A)  + kmul(s51, M_1175);
    r4  = kmul(s73, M_1175) + kmul(s51, O_Z4B);
    o0  = kmul(widen(x7), O_T0) - kmul(widen(x1), M_0899) + r3;
    o1  = kmul(widen(x5), O_T1) - kmul(widen(x3), M_2562) + r4;
    o2  = kmul(widen(x3), O_T2) - kmul(widen(x5), M_2562) + r3;
    o3  = kmul(widen(x1), O_T3) - kmul(widen(x7), M_0899) + r4;
  end

  // Slot k carries odd term t_k
  assign od_vec = {o3, o2, o1, o0};

endmodule

// File: rtl/idct_descale.sv
module idct_descale
  import idct_col_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [HALF_W-1:0] ev_vec,
  input  logic [HALF_W-1:0] od_vec,
  output logic              out_valid,
  output logic [COL_W-1:0]  out_col
);

  logic [COL_W-1:0] res_all;
  logic [COL_W-1:0] out_q, out_nxt;
  logic             vld_q, vld_nxt;

  genvar gk;
  generate
    for (gk = 0; gk < LANES; gk++) begin : g_out
      acc_t sum_l, rnd_l;
      if (gk < HALF) begin : g_add
        assign sum_l = acc_t'(ev_vec[gk*ACC_W +: ACC_W])
                     + acc_t'(od_vec[(HALF-1-gk)*ACC_W +: ACC_W]);
      end else begin : g_sub
        assign sum_l = acc_t'(ev_vec[(LANES-1-gk)*ACC_W +: ACC_W])
                     - acc_t'(od_vec[(gk-HALF)*ACC_W +: ACC_W]);
      end
      assign rnd_l = (sum_l + acc_t'(RND_HALF)) >>> DESCALE;
      assign res_all[gk*COEF_W +: COEF_W] = rnd_l[COEF_W-1:0];
    end
  endgenerate

  always_comb begin
    out_nxt = out_q;
    vld_nxt = in_valid;
    if (in_valid) out_nxt = res_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= out_nxt;
      vld_q <= vld_nxt;
    end
  end

  assign out_valid = vld_q;
  assign out_col   = out_q;

endmodule

// File: rtl/idct_col_core.sv
module idct_col_core
  import idct_col_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coef_valid,
  input  logic [COL_W-1:0] coef_col,
  input  logic             quant_valid,
  input  logic [COL_W-1:0] quant_col,
  output logic             out_valid,
  output logic [COL_W-1:0] out_col
);

  logic             dq_valid;
  logic [COL_W-1:0] dq_col;
  logic [HALF_W-1:0] ev_c, od_c;
  logic [HALF_W-1:0] ev_q, ev_nxt, od_q, od_nxt;
  logic              rot_vld_q, rot_vld_nxt;

  idct_dequant u_dq (
    .clk         (clk),
    .rst_n       (rst_n),
    .coef_valid  (coef_valid),
    .coef_col    (coef_col),
    .quant_valid (quant_valid),
    .quant_col   (quant_col),
    .dq_valid    (dq_valid),
    .dq_col      (dq_col)
  );

  idct_even u_even (
    .x0     (coef_t'(dq_col[0*COEF_W +: COEF_W])),
    .x2     (coef_t'(dq_col[2*COEF_W +: COEF_W])),
    .x4     (coef_t'(dq_col[4*COEF_W +: COEF_W])),
    .x6     (coef_t'(dq_col[6*COEF_W +: COEF_W])),
    .ev_vec (ev_c)
  );

  idct_odd u_odd (
    .x1     (coef_t'(dq_col[1*COEF_W +: COEF_W])),
    .x3     (coef_t'(dq_col[3*COEF_W +: COEF_W])),
    .x5     (coef_t'(dq_col[5*COEF_W +: COEF_W])),
    .x7     (coef_t'(dq_col[7*COEF_W +: COEF_W])),
    .od_vec (od_c)
  );

  // Rotation stage register
  always_comb begin
    ev_nxt      = ev_q;
    od_nxt      = od_q;
    rot_vld_nxt = dq_valid;
    if (dq_valid) begin
      ev_nxt = ev_c;
      od_nxt = od_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q      <= '0;
      od_q      <= '0;
      rot_vld_q <= 1'b0;
    end else begin
      ev_q      <= ev_nxt;
      od_q      <= od_nxt;
      rot_vld_q <= rot_vld_nxt;
    end
  end

  idct_descale u_ds (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rot_vld_q),
    .ev_vec    (ev_q),
    .od_vec    (od_q),
    .out_valid (out_valid),
    .out_col   (out_col)
  );

endmodule

// File: rtl/idct_col_chk.sv
module idct_col_chk
  import idct_col_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             coef_valid,
  input logic [COL_W-1:0] coef_col,
  input logic             out_valid,
  input logic [COL_W-1:0] out_col
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R4
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!out_valid && out_col == '0);
    end
  end

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (out_valid == $past(coef_valid, 3)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && !out_valid) |-> $stable(out_col));

  // R1
  zero_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && $past(coef_valid, 3) && $past(coef_col, 3) == '0)
      |-> (out_col == '0));

endmodule

bind idct_col_core idct_col_chk u_chk (.*);

// File: tb/sim_idct_col_core.sv
module sim_idct_col_core;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         coef_valid = 1'b0;
  logic [127:0] coef_col = '0;
  logic         quant_valid = 1'b0;
  logic [127:0] quant_col = '0;
  logic         out_valid;
  logic [127:0] out_col;

  always #4 clk = ~clk;

  idct_col_core u0 (
    .clk(clk), .rst_n(rst_n), .coef_valid(coef_valid), .coef_col(coef_col),
    .quant_valid(quant_valid), .quant_col(quant_col),
    .out_valid(out_valid), .out_col(out_col)
  );

  typedef struct {
    int           due;
    logic [127:0] val;
    string        tag;
  } exp_t;

  exp_t         expq[$];
  int           cyc = 0;
  int           n_chk = 0;
  int           n_bad = 0;
  logic [127:0] qmodel = '0;
  logic [127:0] last_out = '0;
  bit           monitor_on = 0;
  bit           done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic logic [127:0] ref_col(input logic [127:0] c,
                                           input logic [127:0] q);
    int d[8];
    int z1, z2, z3, z4, z5, t0, t1, t2, t3;
    int a0, a1, a2, a3, e10, e11, e12, e13;
    int r[8];
    logic [127:0] o;
    for (int i = 0; i < 8; i++) begin
      int p;
      p = int'($signed(c[i*16 +: 16])) * int'($signed(q[i*16 +: 16]));
      d[i] = int'($signed(p[15:0]));
    end
    z1 = (d[2] + d[6]) * 4433;
    a2 = z1 + d[6] * (-15137);
    a3 = z1 + d[2] * 6270;
    a0 = (d[0] + d[4]) * 8192;
    a1 = (d[0] - d[4]) * 8192;
    e10 = a0 + a3; e13 = a0 - a3; e11 = a1 + a2; e12 = a1 - a2;
    t0 = d[7]; t1 = d[5]; t2 = d[3]; t3 = d[1];
    z1 = t0 + t3; z2 = t1 + t2; z3 = t0 + t2; z4 = t1 + t3;
    z5 = (z3 + z4) * 9633;
    t0 = t0 * 2446; t1 = t1 * 16819; t2 = t2 * 25172; t3 = t3 * 12299;
    z1 = z1 * (-7373); z2 = z2 * (-20995);
    z3 = z3 * (-16069) + z5; z4 = z4 * (-3196) + z5;
    t0 = t0 + z1 + z3; t1 = t1 + z2 + z4;
    t2 = t2 + z2 + z3; t3 = t3 + z1 + z4;
    r[0] = e10 + t3; r[7] = e10 - t3;
    r[1] = e11 + t2; r[6] = e11 - t2;
    r[2] = e12 + t1; r[5] = e12 - t1;
    r[3] = e13 + t0; r[4] = e13 - t0;
    for (int i = 0; i < 8; i++) begin
      int s;
      s = (r[i] + 1024) >>> 11;
      o[i*16 +: 16] = s[15:0];
    end
    return o;
  endfunction

  function automatic logic [127:0] splat(input int v);
    logic [127:0] o;
    for (int i = 0; i < 8; i++) o[i*16 +: 16] = v[15:0];
    return o;
  endfunction

  // Drive one cycle of stimulus at the falling edge
  task automatic put(input bit cv, input logic [127:0] c,
                     input bit qv, input logic [127:0] q, input string tag);
    exp_t e;
    @(negedge clk);
    coef_valid  = cv;
    coef_col    = c;
    quant_valid = qv;
    quant_col   = q;
    if (qv) qmodel = q;
    if (cv) begin
      e.due = cyc + 3;
      e.val = ref_col(c, qmodel);
      e.tag = tag;
      expq.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, '0, 1'b0, '0, "");
  endtask

  // Compare every cycle
  always @(negedge clk) begin
    if (monitor_on && !done) begin
      if (expq.size() > 0 && expq[0].due == cyc) begin
        chk(out_valid == 1'b1, "R9", "out_valid on due cycle", out_valid, 1);
        for (int i = 0; i < 8; i++)
          chk(out_col[i*16 +: 16] == expq[0].val[i*16 +: 16], expq[0].tag,
              $sformatf("lane %0d", i),
              longint'($signed(out_col[i*16 +: 16])),
              longint'($signed(expq[0].val[i*16 +: 16])));
        last_out = out_col;
        void'(expq.pop_front());
      end else begin
        chk(out_valid == 1'b0, "R9", "out_valid idle", out_valid, 0);
        chk(out_col == last_out, "R10", "held output", out_col[15:0], last_out[15:0]);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
  end

  initial begin
    logic [127:0] qa, qb, c;
    repeat (3) @(negedge clk);
    // R4: outputs quiet during reset
    chk(out_valid == 1'b0, "R4", "out_valid in reset", out_valid, 0);
    chk(out_col == '0, "R4", "out_col in reset", out_col[15:0], 0);
    @(negedge clk);
    rst_n = 1'b1;
    monitor_on = 1;

    // R4: quantizer cleared, column gives zeros
    put(1'b1, splat(123), 1'b0, '0, "R4");
    idle(4);
    chk(last_out == '0, "R4", "zero after unloaded quantizer", last_out[15:0], 0);

    // R5: DC-only with unit quantizer
    put(1'b0, '0, 1'b1, splat(1), "");
    put(1'b1, 128'd5, 1'b0, '0, "R5");
    idle(4);
    chk(last_out == splat(20), "R5", "DC-only lanes", $signed(last_out[15:0]), 20);
    put(1'b1, 128'h0000_0000_0000_0000_0000_0000_0000_FFF9, 1'b0, '0, "R5");
    idle(4);
    chk(last_out == splat(-28), "R5", "negative DC lanes", $signed(last_out[15:0]), -28);

    // R8: narrowing wraps
    put(1'b1, 128'd32767, 1'b0, '0, "R8");
    idle(4);
    chk(last_out == splat(-4), "R8", "wrap of 4*32767", $signed(last_out[15:0]), -4);

    // R1: dequant product wraps at 16 bits (300*300 -> 24464, *4 -> 32320)
    put(1'b1, 128'd300, 1'b1, splat(300), "R1");
    idle(4);
    chk(last_out == splat(32320), "R1", "wrapped dequant DC", $signed(last_out[15:0]), 32320);

    // R7: single AC term exercises rounding in both directions
    put(1'b0, '0, 1'b1, splat(1), "");
    c = '0; c[2*16 +: 16] = 16'd1;
    put(1'b1, c, 1'b0, '0, "R7");
    idle(4);
    chk($signed(last_out[15:0]) == 5, "R7", "lane0 round", $signed(last_out[15:0]), 5);
    chk($signed(last_out[3*16 +: 16]) == -5, "R7", "lane3 round",
        $signed(last_out[3*16 +: 16]), -5);

    // R3 then R2: same-cycle load bypass, then retention
    qa = splat(2);
    qb = '0;
    for (int i = 0; i < 8; i++) qb[i*16 +: 16] = 16'(i + 3);
    put(1'b0, '0, 1'b1, qa, "");
    c = '0;
    for (int i = 0; i < 8; i++) c[i*16 +: 16] = 16'(i * 7 - 20);
    put(1'b1, c, 1'b1, qb, "R3");
    put(1'b1, c, 1'b0, qa, "R2");
    idle(4);

    // R6, R9: back-to-back and gapped random columns
    for (int n = 0; n < 300; n++) begin
      logic [127:0] rc, rq;
      bit ld;
      for (int i = 0; i < 8; i++) begin
        rc[i*16 +: 16] = (n % 5 == 0) ? 16'($urandom) : 16'($signed(11'($urandom)));
        rq[i*16 +: 16] = 16'($urandom_range(1, 80));
      end
      ld = ($urandom_range(0, 3) == 0);
      put($urandom_range(0, 4) != 0, rc, ld, rq, (n % 2) ? "R6" : "R9");
    end
    idle(6);
    chk(expq.size() == 0, "R9", "all columns delivered", expq.size(), 0);
    done = 1;
    summary();
  end

endmodule